// File: doc/BRIEF.md
# Fractional Clock-Enable Divider

This block turns a fast input clock into a one-cycle enable pulse whose average spacing is a fixed-point ratio with an integer part and a fractional part. A down counter measures out each output period. Whenever it finishes, a small phase accumulator adds the fractional part of the ratio. If that addition overflows, the next period is one cycle longer than the integer part; otherwise it lasts exactly the integer part. Across many periods, the average spacing between pulses then equals the programmed ratio exactly.

Typical use is as a clock enable for logic that runs at a rational fraction of the main clock rate. Another use is as the feedback divider model in a fractional synthesis loop. The ratio word has 5 integer bits and 5 fractional bits by default. A flag reports whether the current period is a long one, meaning integer plus one cycle.

Top module: `frac_clk_div`

## Requirements
- R1: The period is set by a down counter. An output period of N cycles produces exactly one `pulse_o` cycle, in its last cycle, and `pulse_o` is low in the other N-1 cycles.
- R2: `ratio_i` holds the integer part in bits [9:5] and the fraction, in units of 1/32, in bits [4:0]. The word {5, 16} (5.5) gives periods 5, 5, 6, 5, 6, ... after reset, so two pulses occur every 11 cycles.
- R3: At each pulse, the 5-bit accumulator adds the fraction. A carry out makes the next period integer+1 cycles long. Measured from any pulse, the 32*k following periods total exactly 32*k*integer + k*fraction cycles.
- R4: Each period is either integer or integer+1 cycles long, and its length is chosen only at the pulse that begins it. `long_o` is high for every cycle of a period of integer+1 cycles and low for every cycle of a period of integer cycles.
- R5: The word {1, 0} makes `pulse_o` high on every cycle.
- R6: With a fraction of zero, every period lasts exactly the integer part and `long_o` stays low.
- R7: `ratio_i` is sampled only at the clock edge that ends a pulse cycle, and while reset is held. A change made in the middle of a period leaves that period's length unchanged and takes effect from the next period.
- R8: An integer field of 0 is treated as 1, so the word {0, 0} gives a pulse every cycle and the counter never stalls.
- R9: `rst` is synchronous and active high. While it is held, `pulse_o` and `long_o` are low and the accumulator is cleared. After release, the first pulse occurs in the N-th cycle, where N is the effective integer part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio_i | input | 10 | Division ratio: integer in [9:5], fraction in [4:0] |
| pulse_o | output | 1 | One-cycle enable at the end of each output period |
| long_o | output | 1 | High while the current period is integer+1 cycles long |

## Verification
The bench builds the block with its default widths: 5 integer bits and 5 fractional bits. This makes the full 32-period fractional cycle short enough to run several times over, for a range of ratio words. It also puts the largest period, 32 cycles from the word {31, 31}, within reach, which exercises the extra counter bit. The fractional case at its smallest scale (integer 0 with a fraction) is checked as well. A behavioural model in the bench predicts `pulse_o` and `long_o` every cycle. Directed measurements of period lengths and summed cycle counts cover the 5.5 pattern, the mid-period ratio change and the unit ratios.

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int INT_W  = 5,
  parameter int FRAC_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [INT_W+FRAC_W-1:0] ratio_i,
  output logic                    pulse_o,
  output logic                    long_o
);

  localparam int CNT_W = INT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(2 ** INT_W);

  logic [INT_W-1:0]  int_f;
  logic [FRAC_W-1:0] frac_f;
  logic [CNT_W-1:0]  int_eff;
  logic [CNT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   acc_sum;
  logic              carry;
  logic              boundary;
  logic              long_q;

  assign int_f    = ratio_i[INT_W+FRAC_W-1:FRAC_W];
  assign frac_f   = ratio_i[FRAC_W-1:0];
  assign int_eff  = (int_f == '0) ? CNT_W'(1) : {1'b0, int_f};
  assign acc_sum  = {1'b0, acc_q} + {1'b0, frac_f};
  assign carry    = acc_sum[FRAC_W];
  assign boundary = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= int_eff;
      acc_q  <= '0;
      long_q <= 1'b0;
    end else if (boundary) begin
      cnt_q  <= int_eff + {{(CNT_W-1){1'b0}}, carry};
      acc_q  <= acc_sum[FRAC_W-1:0];
      long_q <= carry;
    end else begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign pulse_o = boundary & ~rst;
  assign long_o  = long_q;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) && (cnt_q <= CNT_MAX)); // R8

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    !pulse_o |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R1

  AST_LONG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pulse_o |=> $stable(long_o)); // R4

  AST_FRAC_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pulse_o && frac_f == '0) |=> !long_o); // R6

  AST_UNIT_RATE: assert property (@(posedge clk) disable iff (rst)
    (pulse_o && int_f <= INT_W'(1) && frac_f == '0) |=> pulse_o); // R5

endmodule

// File: tb/frac_clk_div_bench.sv
`timescale 1ns/1ps
module frac_clk_div_bench;
  localparam int IW = 5;
  localparam int FW = 5;
  localparam int FMOD = 2 ** FW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IW+FW-1:0] ratio = {5'd5, 5'd16};
  logic pulse_o, long_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  frac_clk_div #(.INT_W(IW), .FRAC_W(FW)) u_frac_clk_div (
    .clk(clk), .rst(rst), .ratio_i(ratio), .pulse_o(pulse_o), .long_o(long_o));

  always #10 clk = ~clk;

  function automatic int eff_of(logic [IW+FW-1:0] r);
    int i = int'(r[IW+FW-1:FW]);
    return (i == 0) ? 1 : i;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference, updated with the inputs the next edge will see
  int m_rem, m_acc, m_long;
  bit m_init = 1'b0;
  always @(negedge clk) begin
    if (m_init && !done) begin
      int ep, el;
      ep = (!rst && m_rem == 1) ? 1 : 0;
      el = m_long;
      checks++;
      if (pulse_o !== ep[0] || long_o !== el[0]) begin
        failures++;
        $display("FAIL R1 R4 model pulse=%0b/%0d long=%0b/%0d", pulse_o, ep, long_o, el);
      end
    end
    if (rst) begin
      m_rem = eff_of(ratio); m_acc = 0; m_long = 0; m_init = 1'b1;
    end else if (m_init) begin
      if (m_rem == 1) begin
        int s;
        s = m_acc + int'(ratio[FW-1:0]);
        m_long = (s >= FMOD) ? 1 : 0;
        m_acc = s % FMOD;
        m_rem = eff_of(ratio) + m_long;
      end else m_rem--;
    end
  end

  task automatic start(logic [IW+FW-1:0] r);
    @(posedge clk); #2; rst = 1'b1; ratio = r;
    @(posedge clk); #2; rst = 1'b0;
  endtask

  task automatic next_pulse(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk); cyc++;
    end while (pulse_o !== 1'b1);
  endtask

  task automatic run_avg(logic [IW+FW-1:0] r, int k);
    int g, sum, e, f;
    e = eff_of(r); f = int'(r[FW-1:0]); sum = 0;
    start(r);
    next_pulse(g);
    chk("R9 first period", g, e);
    for (int p = 0; p < 32 * k; p++) begin
      next_pulse(g);
      sum += g;
      chk("R4 long flag", int'(long_o), (g == e + 1) ? 1 : 0);
      if (f == 0) chk("R6 integer period", g, e);
      else if (g != e) chk("R4 period length", g, e + 1);
    end
    chk("R3 summed cycles", sum, 32 * k * e + k * f);
  endtask

  initial begin
    int g, g2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 pulse in reset", int'(pulse_o), 0);
    chk("R9 long in reset", int'(long_o), 0);

    start({5'd5, 5'd16});
    next_pulse(g); chk("R9 first period 5.5", g, 5);
    chk("R2 long p1", int'(long_o), 0);
    next_pulse(g); chk("R2 period 2", g, 5);
    chk("R2 long p2", int'(long_o), 0);
    next_pulse(g2); chk("R2 period 3", g2, 6);
    chk("R2 long p3", int'(long_o), 1);
    chk("R2 two pulses per 11", g + g2, 11);
    next_pulse(g); chk("R2 period 4", g, 5);
    next_pulse(g); chk("R2 period 5", g, 6);

    run_avg({5'd5, 5'd16}, 2);
    run_avg({5'd3, 5'd0}, 1);
    run_avg({5'd1, 5'd0}, 1);
    run_avg({5'd7, 5'd3}, 3);
    run_avg({5'd31, 5'd31}, 1);
    run_avg({5'd0, 5'd8}, 1);

    start({5'd1, 5'd0});
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); chk("R5 pulse every cycle", int'(pulse_o), 1);
    end

    start({5'd0, 5'd0});
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); chk("R8 zero integer as one", int'(pulse_o), 1);
    end

    start({5'd7, 5'd0});
    next_pulse(g); chk("R7 first period", g, 7);
    @(posedge clk); @(posedge clk); #2; ratio = {5'd3, 5'd0};
    next_pulse(g); chk("R7 period kept", g, 6);
    next_pulse(g); chk("R7 new ratio", g, 3);
    next_pulse(g); chk("R7 new ratio again", g, 3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule